// File: doc/BRIEF.md
# Out-of-Range Access Error Logger

This block sits beside a memory controller's command acceptance point and watches every accepted command. From each command it works out the last byte the command touches. It compares that byte against a programmed memory size. A command that reaches past the end of memory, or whose end address wraps past the top of the address space, counts as a fault.

The logger only observes. It has no ready or stall output, so a faulting command still goes through and runs. The first fault is stored in a capture record. That record stays until software reads its address word, which empties it. A sticky status bit shows that more faults arrived before the first one was acknowledged, whether or not their details were kept.

Software uses a small register port to:
- read the status and the capture record,
- acknowledge status bits,
- set a per-bit interrupt mask.

The interrupt output is registered.

Top module: `oor_logger`

## Requirements
- R1: A cycle with `cmd_valid` high and a fault sets status bit 0, visible in STATUS (register 0, bit 0) from the next cycle.
- R2: A command is a fault when `{1'b0,cmd_addr} + cmd_len` is at or above `mem_size`, computed one bit wider than the address. `cmd_len` encodes the byte count minus one. A command inside the range, or any cycle with `cmd_valid` low, leaves all state unchanged.
- R3: Writing register 1 (ACK) clears status bit 0 where write-data bit 0 is 1, and clears status bit 1 where write-data bit 1 is 1. If a fault sets the same bit in the same cycle, that bit stays set.
- R4: A fault while status bit 0 is already set sets status bit 1 (STATUS bit 1).
- R5: A fault with no valid record stores a record. Register 3 then reads the start address. Register 4 then reads the length field in bits [7:0], the source ID in bits [11:8], the write flag in bit 16 and the valid flag in bit 31.
- R6: A fault that arrives while a valid record is held changes nothing in registers 3 and 4. This includes a fault in the same cycle as the emptying read.
- R7: A read of register 3 (`reg_en` high, `reg_wr` low) empties the record: registers 3 and 4 read zero from the next cycle.
- R8: Register 2 (MASK, bits [1:0]) is read/write. `irq` equals the OR of STATUS bits ANDed with MASK bits, delayed by one cycle.
- R9: After reset, status, mask, record and `irq` are all zero.
- R10: Register 1 and addresses 5 to 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_size | input | ADDR_W+1 | Programmed memory size in bytes |
| cmd_valid | input | 1 | A command is accepted this cycle |
| cmd_addr | input | ADDR_W | Command start byte address |
| cmd_len | input | LEN_W | Command byte count minus one |
| cmd_write | input | 1 | 1 for write, 0 for read |
| cmd_src | input | SRC_W | Source port ID |
| reg_en | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 for write, 0 for read |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on `reg_addr`) |
| irq | output | 1 | Registered, masked interrupt |

## Verification
The bench builds the logger with a 16-bit address, an 8-bit length and a 4-bit source ID. At this address width, a `mem_size` of 0x10000 is the full address space. A command starting near 0xFFF0 can then carry its end past the top, which exercises the wrap case. The exact boundary at `mem_size` is also reachable with small lengths. After the directed cases, a stretch of mixed traffic drives faults, acknowledges, mask writes and emptying reads into the same cycles, covering the collision orderings.

// File: rtl/oor_pkg.sv
package oor_pkg;
    localparam int REG_W  = 32;
    localparam int RSEL_W = 3;

    typedef enum logic [RSEL_W-1:0] {
        SEL_STATUS = 3'd0,
        SEL_ACK    = 3'd1,
        SEL_MASK   = 3'd2,
        SEL_CADDR  = 3'd3,
        SEL_CINFO  = 3'd4
    } reg_sel_e;

    // Record info word field positions
    localparam int INFO_LEN_LSB = 0;
    localparam int INFO_SRC_LSB = 8;
    localparam int INFO_WR_BIT  = 16;
    localparam int INFO_VLD_BIT = 31;
endpackage

// File: rtl/oor_span_check.sv
module oor_span_check #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [ADDR_W:0]   limit_i,
    output logic              fault_o
);
    localparam int SUM_W = ADDR_W + 1;

    logic [SUM_W-1:0] last_byte;

    always_comb begin
        // One extra bit holds the carry, so a wrapped end compares as large
        last_byte = {1'b0, addr_i} + SUM_W'(len_i);
        fault_o   = (last_byte >= limit_i);
    end
endmodule

// File: rtl/oor_capture.sv
module oor_capture #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 8,
    parameter int SRC_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_i,
    input  logic              drop_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic              wr_i,
    input  logic [SRC_W-1:0]  src_i,
    output logic              vld_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [LEN_W-1:0]  len_o,
    output logic              wr_o,
    output logic [SRC_W-1:0]  src_o
);
    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic              wr;
        logic [SRC_W-1:0]  src;
    } rec_t;

    rec_t rec_d, rec_q;

    always_comb begin
        rec_d = rec_q;
        if (take_i && !rec_q.vld) begin
            rec_d.vld  = 1'b1;
            rec_d.addr = addr_i;
            rec_d.len  = len_i;
            rec_d.wr   = wr_i;
            rec_d.src  = src_i;
        end else if (drop_i) begin
            rec_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rec_q <= '0;
        else        rec_q <= rec_d;
    end

    assign vld_o  = rec_q.vld;
    assign addr_o = rec_q.addr;
    assign len_o  = rec_q.len;
    assign wr_o   = rec_q.wr;
    assign src_o  = rec_q.src;

    // A held record is never overwritten by a later fault
    assert_hold_record_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_q.vld && !drop_i) |=> ($stable(addr_o) && $stable(src_o) && vld_o));

    // An emptying read without a new capture leaves nothing behind
    assert_read_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_i && rec_q.vld) |=> (!vld_o && addr_o == '0));

    // An empty record takes the fault's address
    assert_first_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && !vld_o) |=> (vld_o && addr_o == $past(addr_i)));
endmodule

// File: rtl/oor_irq_status.sv
module oor_irq_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fault_i,
    input  logic       ack_we_i,
    input  logic       mask_we_i,
    input  logic [1:0] wdata_i,
    output logic [1:0] status_o,
    output logic [1:0] mask_o,
    output logic       irq_o
);
    typedef struct packed {
        logic [1:0] status;
        logic [1:0] mask;
        logic       irq;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Acknowledge first; a fault in the same cycle overrides it
        if (ack_we_i) st_d.status = st_q.status & ~wdata_i;
        if (fault_i) begin
            st_d.status[0] = 1'b1;
            if (st_q.status[0]) st_d.status[1] = 1'b1;
        end
        if (mask_we_i) st_d.mask = wdata_i;
        st_d.irq = |(st_q.status & st_q.mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o = st_q.status;
    assign mask_o   = st_q.mask;
    assign irq_o    = st_q.irq;

    assert_fault_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fault_i |=> status_o[0]);

    assert_second_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_i && status_o[0]) |=> status_o[1]);

    assert_ack_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_we_i && wdata_i[0] && !fault_i) |=> !status_o[0]);

    assert_irq_lag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(|(status_o & mask_o))));
endmodule

// File: rtl/oor_logger.sv
module oor_logger
    import oor_pkg::*;
#(
    parameter int ADDR_W = 32,  // at most 32
    parameter int LEN_W  = 8,   // at most 8
    parameter int SRC_W  = 4    // at most 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W:0]     mem_size,
    input  logic                cmd_valid,
    input  logic [ADDR_W-1:0]   cmd_addr,
    input  logic [LEN_W-1:0]    cmd_len,
    input  logic                cmd_write,
    input  logic [SRC_W-1:0]    cmd_src,
    input  logic                reg_en,
    input  logic                reg_wr,
    input  logic [RSEL_W-1:0]   reg_addr,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    output logic                irq
);
    logic              span_fault, fault;
    logic              ack_we, mask_we, rec_drop;
    logic              rec_vld, rec_wr;
    logic [ADDR_W-1:0] rec_addr;
    logic [LEN_W-1:0]  rec_len;
    logic [SRC_W-1:0]  rec_src;
    logic [1:0]        status, mask;

    oor_span_check #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_span (
        .addr_i (cmd_addr),
        .len_i  (cmd_len),
        .limit_i(mem_size),
        .fault_o(span_fault)
    );

    always_comb begin
        fault    = cmd_valid && span_fault;
        ack_we   = reg_en && reg_wr && (reg_addr == SEL_ACK);
        mask_we  = reg_en && reg_wr && (reg_addr == SEL_MASK);
        rec_drop = reg_en && !reg_wr && (reg_addr == SEL_CADDR);
    end

    oor_capture #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SRC_W(SRC_W)) u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .take_i(fault),
        .drop_i(rec_drop),
        .addr_i(cmd_addr),
        .len_i (cmd_len),
        .wr_i  (cmd_write),
        .src_i (cmd_src),
        .vld_o (rec_vld),
        .addr_o(rec_addr),
        .len_o (rec_len),
        .wr_o  (rec_wr),
        .src_o (rec_src)
    );

    oor_irq_status u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .fault_i  (fault),
        .ack_we_i (ack_we),
        .mask_we_i(mask_we),
        .wdata_i  (reg_wdata[1:0]),
        .status_o (status),
        .mask_o   (mask),
        .irq_o    (irq)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            SEL_STATUS: reg_rdata[1:0] = status;
            SEL_MASK:   reg_rdata[1:0] = mask;
            SEL_CADDR:  reg_rdata[ADDR_W-1:0] = rec_addr;
            SEL_CINFO: begin
                reg_rdata[INFO_LEN_LSB +: LEN_W] = rec_len;
                reg_rdata[INFO_SRC_LSB +: SRC_W] = rec_src;
                reg_rdata[INFO_WR_BIT]           = rec_wr;
                reg_rdata[INFO_VLD_BIT]          = rec_vld;
            end
            default:    reg_rdata = '0;
        endcase
    end

    // In-range traffic never touches the status
    assert_inrange_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault && !ack_we) |=> (status == $past(status)));
endmodule

// File: tb/oor_logger_tb.sv
`timescale 1ns/1ps
module oor_logger_tb;
    localparam int AW = 16, LW = 8, SW = 4;

    logic clk = 0, rst_n = 0;
    logic [AW:0] mem_size = 17'h01000;
    logic cmd_valid = 0, cmd_write = 0;
    logic [AW-1:0] cmd_addr = 0;
    logic [LW-1:0] cmd_len = 0;
    logic [SW-1:0] cmd_src = 0;
    logic reg_en = 0, reg_wr = 0;
    logic [2:0] reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic irq;

    always #2 clk = ~clk;

    oor_logger #(.ADDR_W(AW), .LEN_W(LW), .SRC_W(SW)) u_dut (.*);

    int vecs = 0, bad = 0;
    int m_st0, m_st1, m_mask, m_vld, m_addr, m_len, m_wr, m_src, m_irq;

    // Reference model, updated at every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st0 = 0; m_st1 = 0; m_mask = 0; m_vld = 0;
            m_addr = 0; m_len = 0; m_wr = 0; m_src = 0; m_irq = 0;
        end else begin
            int err, n0, n1, ack, rd3;
            longint last;
            last = longint'(cmd_addr) + longint'(cmd_len);
            err  = (cmd_valid && last >= longint'(mem_size)) ? 1 : 0;
            ack  = (reg_en && reg_wr && reg_addr == 1) ? 1 : 0;
            rd3  = (reg_en && !reg_wr && reg_addr == 3) ? 1 : 0;
            m_irq = ((m_st0 & m_mask) | (m_st1 & (m_mask >> 1))) & 1;
            n0 = m_st0; n1 = m_st1;
            if (ack && reg_wdata[0]) n0 = 0;
            if (ack && reg_wdata[1]) n1 = 0;
            if (err) begin n0 = 1; if (m_st0) n1 = 1; end
            if (err && !m_vld) begin
                m_vld = 1; m_addr = cmd_addr; m_len = cmd_len;
                m_wr = cmd_write; m_src = cmd_src;
            end else if (rd3) begin
                m_vld = 0; m_addr = 0; m_len = 0; m_wr = 0; m_src = 0;
            end
            if (reg_en && reg_wr && reg_addr == 2) m_mask = reg_wdata[1:0];
            m_st0 = n0; m_st1 = n1;
        end
    end

    function automatic logic [31:0] exp_rd(input int a);
        case (a)
            0: return 32'(m_st0 | (m_st1 << 1));
            2: return 32'(m_mask);
            3: return 32'(m_addr);
            4: return 32'(m_len | (m_src << 8) | (m_wr << 16) | (m_vld << 31));
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag(input int a);
        case (a)
            0: return "R1 R4 R3 R2";
            2: return "R8";
            3: return "R5 R6 R7";
            4: return "R5 R6 R7";
            default: return "R10";
        endcase
    endfunction

    // Compare on every falling edge
    always @(negedge clk) if (rst_n) begin
        logic [31:0] e;
        e = exp_rd(int'(reg_addr));
        vecs++;
        if (reg_rdata !== e) begin
            bad++;
            $display("FAIL %s reg%0d: got %h expected %h", tag(int'(reg_addr)), reg_addr, reg_rdata, e);
        end
        if (irq !== m_irq[0]) begin
            bad++;
            $display("FAIL R8 irq: got %b expected %0d", irq, m_irq);
        end
    end

    task automatic tick();
        @(negedge clk); #1;
        cmd_valid = 0; reg_en = 0; reg_wr = 0;
    endtask
    task automatic cmd(input int a, input int l, input bit w, input int s);
        cmd_valid = 1; cmd_addr = AW'(a); cmd_len = LW'(l); cmd_write = w; cmd_src = SW'(s);
    endtask
    task automatic rd(input int a);
        reg_en = 1; reg_wr = 0; reg_addr = 3'(a);
    endtask
    task automatic wr(input int a, input int d);
        reg_en = 1; reg_wr = 1; reg_addr = 3'(a); reg_wdata = 32'(d);
    endtask
    task automatic look(input int a, input int n);
        reg_addr = 3'(a);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        #(200000 * 4);
        bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1;
        // R9 reset state: every register read back
        for (int a = 0; a < 8; a++) look(a, 1);
        wr(2, 3); tick();                       // R8 mask write
        cmd(16'h0FF0, 8'h0F, 0, 1); look(0, 2); // R2 last byte 0xFFF inside
        cmd(16'h3000, 8'h00, 0, 2); reg_addr = 0; cmd_valid = 0; tick(); // R2 valid low ignored
        cmd(16'h0FF0, 8'h10, 1, 3); look(0, 3); // R1 boundary fault, R8 irq
        look(4, 1); look(3, 1);                 // R5 record
        cmd(16'h2000, 8'h07, 0, 5); look(4, 2); // R4 + R6 discard
        rd(3); tick(); look(4, 1); look(3, 1);  // R7 empty
        cmd(16'h1800, 8'h01, 0, 6); look(4, 1); // R5 new capture
        wr(1, 1); cmd(16'h1900, 8'h00, 1, 7); tick(); look(0, 1); // R3 fault wins
        wr(1, 3); tick(); look(0, 2);           // R3 clear both
        rd(3); cmd(16'h1A00, 8'h02, 1, 8); tick(); look(4, 1); // R6 collides with read
        mem_size = 17'h10000;
        cmd(16'hFFF0, 8'h0F, 0, 9); look(0, 1); // R2 end 0xFFFF inside
        cmd(16'hFFF0, 8'h20, 1, 10); look(4, 1);// R2 wrap flagged
        wr(2, 2); tick(); look(0, 2); look(2, 1);
        for (int a = 5; a < 8; a++) look(a, 1); look(1, 1); // R10
        for (int i = 0; i < 3000; i++) begin
            mem_size = 17'($urandom_range(32'h10000, 32'h0F000));
            if ($urandom_range(0, 2) == 0)
                cmd(int'($urandom_range(0, 32'hFFFF)), int'($urandom_range(0, 255)), 1'($urandom), int'($urandom_range(0, 15)));
            case ($urandom_range(0, 5))
                0: wr(1, int'($urandom_range(0, 3)));
                1: wr(2, int'($urandom_range(0, 3)));
                2: rd(3);
                default: reg_addr = 3'($urandom_range(0, 7));
            endcase
            tick();
        end
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end
endmodule